// File: doc/BRIEF.md
# USB Endpoint Handshake Response Controller

This block owns the two-bit response mode of one USB endpoint pipe and turns every token seen on that pipe into a handshake choice: NAK, ACK, a data phase, or STALL. Software sets the mode through a plain write strobe. Protocol events seen by the device side override that mode. A received setup packet forces NAK and raises a lock flag that blocks software writes until software clears it. Oversize packets in buffer mode and control sequence errors force STALL. A bus reset forces NAK.

When the pipe acts as a host and a start-split has been sent, the split-status flag is raised. Software writes made while that flag is set are held back and take effect when the complete-split finishes, so a split that has started always runs to its end. While an automatic address-assignment request is being handled, the mode field is bypassed. A busy output tells software that a transaction on the pipe is still open, so it can wait for it before changing the pipe configuration.

Top module: `ep_resp_ctrl`

## Requirements
- R1: After reset the mode is 00, the setup lock flag is 0, the split flag is 0, busy is 0 and no handshake is valid.
- R2: A software write with the lock flag at 0 and no split open sets the mode to the written value on the next cycle.
- R3: One cycle after a token, hs_vld_o is 1 with hs_code_o encoded NAK=0, ACK=1, DATA=2, STALL=3. Mode 00 gives NAK, and modes 10 and 11 both give STALL.
- R4: In mode 01, an OUT (kind 0) or SETUP (kind 2) token gets ACK if buf_free_i is 1 and NAK otherwise. An IN (kind 1) token gets DATA if buf_full_i is 1 and NAK otherwise. The reserved kind 3 always gets NAK.
- R5: In device mode, setup_rx_i forces the mode to 00 and sets the lock flag on the next cycle.
- R6: While the lock flag is 1, software writes are dropped. valid_clr_i clears the flag, but a write in that same cycle is still dropped. setup_rx_i wins over valid_clr_i when both arrive in the same cycle.
- R7: In device mode, oversize_i forces the mode to 10 only when the mode is 01. In any other mode it has no effect.
- R8: In device mode, seq_err_i forces the mode to 10.
- R9: bus_rst_i forces the mode to 00 and clears the split flag, any held write and busy.
- R10: When events coincide, the order of priority is bus reset, then setup, then the STALL causes, then the software write.
- R11: While auto_setaddr_i is 1, the mode is ignored. OUT and SETUP tokens get ACK, and IN tokens get DATA.
- R12: In host mode, ssplit_issue_i sets the split flag. A software write while the flag is 1 leaves the mode unchanged. On csplit_done_i the flag clears and the held value becomes the mode on the next cycle. A forced update discards the held value.
- R13: busy_o goes to 1 together with an ACK or DATA handshake, returns to 0 after txn_done_i, and is also 1 while the split flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_mode_i | input | 1 | 1 selects host function, 0 selects device function |
| sw_wr_en_i | input | 1 | Software write strobe for the mode field |
| sw_wr_data_i | input | 2 | Value to write into the mode field |
| valid_clr_i | input | 1 | Clears the setup lock flag |
| setup_rx_i | input | 1 | A setup packet was received |
| oversize_i | input | 1 | A received data packet exceeded the maximum size |
| seq_err_i | input | 1 | A control transfer sequence error was detected |
| bus_rst_i | input | 1 | A USB bus reset was detected |
| auto_setaddr_i | input | 1 | An automatic address request is being handled |
| ssplit_issue_i | input | 1 | A start-split was issued (host mode) |
| csplit_done_i | input | 1 | The complete-split finished |
| tok_vld_i | input | 1 | A token is present |
| tok_kind_i | input | 2 | Token kind: 0 OUT, 1 IN, 2 SETUP, 3 reserved |
| buf_free_i | input | 1 | A free buffer of sufficient size is available |
| buf_full_i | input | 1 | A filled buffer is ready to send |
| txn_done_i | input | 1 | The open transaction has ended |
| mode_o | output | 2 | Current mode field |
| setup_valid_o | output | 1 | Setup lock flag |
| split_sts_o | output | 1 | Split in progress |
| hs_vld_o | output | 1 | Handshake decision is valid |
| hs_code_o | output | 2 | Handshake decision |
| busy_o | output | 1 | A transaction on the pipe is open |

## Verification
The bench targets coinciding events. Setup arriving together with a sequence error must end in NAK with the lock set, and a design with the ladder reversed would end in STALL. A write in the same cycle as the lock clear must be dropped, and a design that looked at the next lock state would accept it. Oversize in modes other than buffer must leave the mode alone, and a design that forced STALL every time would fail that case. In host mode, a write to NAK during an open split must not reach the mode until the complete-split, and a design that applied it at once would drop the handshake for the rest of the split.

// File: rtl/ep_resp_pkg.sv
package ep_resp_pkg;

    localparam int MODE_W = 2;
    localparam int TOK_W  = 2;
    localparam int HS_W   = 2;

    localparam logic [MODE_W-1:0] MODE_NAK   = 2'b00;
    localparam logic [MODE_W-1:0] MODE_BUF   = 2'b01;
    localparam logic [MODE_W-1:0] MODE_STALL = 2'b10;

    localparam logic [TOK_W-1:0] TOK_OUT   = 2'd0;
    localparam logic [TOK_W-1:0] TOK_IN    = 2'd1;
    localparam logic [TOK_W-1:0] TOK_SETUP = 2'd2;
    localparam logic [TOK_W-1:0] TOK_RSV   = 2'd3;

    localparam logic [HS_W-1:0] HS_NAK   = 2'd0;
    localparam logic [HS_W-1:0] HS_ACK   = 2'd1;
    localparam logic [HS_W-1:0] HS_DATA  = 2'd2;
    localparam logic [HS_W-1:0] HS_STALL = 2'd3;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              lock;
        logic              split;
        logic              held_vld;
        logic [MODE_W-1:0] held_mode;
    } ctl_state_t;

    typedef struct packed {
        logic            vld;
        logic [HS_W-1:0] code;
    } hs_state_t;

endpackage

// File: rtl/ep_mode_ctl.sv
module ep_mode_ctl
    import ep_resp_pkg::*;
#(
    parameter bit SPLIT_EN = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              host_mode_i,
    input  logic              sw_wr_en_i,
    input  logic [MODE_W-1:0] sw_wr_data_i,
    input  logic              valid_clr_i,
    input  logic              setup_rx_i,
    input  logic              oversize_i,
    input  logic              seq_err_i,
    input  logic              bus_rst_i,
    input  logic              ssplit_issue_i,
    input  logic              csplit_done_i,
    output logic [MODE_W-1:0] mode_o,
    output logic              lock_o,
    output logic              split_o
);

    ctl_state_t st_d, st_q;
    logic       wr_take;
    logic       dev_side;

    always_comb begin
        st_d     = st_q;
        wr_take  = sw_wr_en_i && !st_q.lock;
        dev_side = !host_mode_i;

        // lock release by software
        if (valid_clr_i) begin
            st_d.lock = 1'b0;
        end

        // split completion applies any held write
        if (SPLIT_EN && st_q.split && csplit_done_i) begin
            st_d.split = 1'b0;
            if (st_q.held_vld) begin
                st_d.mode     = st_q.held_mode;
                st_d.held_vld = 1'b0;
            end
        end

        if (SPLIT_EN && host_mode_i && ssplit_issue_i) begin
            st_d.split = 1'b1;
        end

        // lowest priority: software write
        if (wr_take) begin
            if (st_q.split && !csplit_done_i) begin
                st_d.held_vld  = 1'b1;
                st_d.held_mode = sw_wr_data_i;
            end else begin
                st_d.mode     = sw_wr_data_i;
                st_d.held_vld = 1'b0;
            end
        end

        // STALL causes
        if (dev_side && oversize_i && st_q.mode == MODE_BUF) begin
            st_d.mode     = MODE_STALL;
            st_d.held_vld = 1'b0;
        end
        if (dev_side && seq_err_i) begin
            st_d.mode     = MODE_STALL;
            st_d.held_vld = 1'b0;
        end

        // setup reception
        if (dev_side && setup_rx_i) begin
            st_d.mode     = MODE_NAK;
            st_d.lock     = 1'b1;
            st_d.held_vld = 1'b0;
        end

        // bus reset, highest priority
        if (bus_rst_i) begin
            st_d.mode     = MODE_NAK;
            st_d.split    = 1'b0;
            st_d.held_vld = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{mode: MODE_NAK, lock: 1'b0, split: 1'b0,
                      held_vld: 1'b0, held_mode: MODE_NAK};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o  = st_q.mode;
    assign lock_o  = st_q.lock;
    assign split_o = st_q.split;

endmodule

// File: rtl/ep_hs_pick.sv
module ep_hs_pick
    import ep_resp_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tok_vld_i,
    input  logic [TOK_W-1:0]  tok_kind_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              buf_free_i,
    input  logic              buf_full_i,
    input  logic              auto_setaddr_i,
    output logic              accept_o,
    output logic              hs_vld_o,
    output logic [HS_W-1:0]   hs_code_o
);

    hs_state_t hs_d, hs_q;
    logic      is_in;
    logic      bufd_ok;

    always_comb begin
        is_in   = (tok_kind_i == TOK_IN);
        bufd_ok = is_in ? buf_full_i : buf_free_i;
        hs_d.vld  = tok_vld_i;
        hs_d.code = HS_NAK;

        if (tok_kind_i == TOK_RSV) begin
            hs_d.code = HS_NAK;
        end else if (auto_setaddr_i) begin
            hs_d.code = is_in ? HS_DATA : HS_ACK;
        end else if (mode_i[1]) begin
            hs_d.code = HS_STALL;
        end else if (mode_i == MODE_BUF) begin
            if (bufd_ok) begin
                hs_d.code = is_in ? HS_DATA : HS_ACK;
            end else begin
                hs_d.code = HS_NAK;
            end
        end else begin
            hs_d.code = HS_NAK;
        end

        accept_o = tok_vld_i && (hs_d.code == HS_ACK || hs_d.code == HS_DATA);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hs_q <= '{vld: 1'b0, code: HS_NAK};
        end else begin
            hs_q <= hs_d;
        end
    end

    assign hs_vld_o  = hs_q.vld;
    assign hs_code_o = hs_q.code;

endmodule

// File: rtl/ep_busy_trk.sv
module ep_busy_trk (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic accept_i,
    input  logic txn_done_i,
    input  logic bus_rst_i,
    output logic open_o
);

    logic open_d, open_q;

    always_comb begin
        open_d = open_q;
        if (txn_done_i) begin
            open_d = 1'b0;
        end
        if (accept_i) begin
            open_d = 1'b1;
        end
        if (bus_rst_i) begin
            open_d = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            open_q <= 1'b0;
        end else begin
            open_q <= open_d;
        end
    end

    assign open_o = open_q;

endmodule

// File: rtl/ep_resp_ctrl.sv
module ep_resp_ctrl
    import ep_resp_pkg::*;
#(
    parameter bit SPLIT_EN = 1'b1
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       host_mode_i,
    input  logic       sw_wr_en_i,
    input  logic [1:0] sw_wr_data_i,
    input  logic       valid_clr_i,
    input  logic       setup_rx_i,
    input  logic       oversize_i,
    input  logic       seq_err_i,
    input  logic       bus_rst_i,
    input  logic       auto_setaddr_i,
    input  logic       ssplit_issue_i,
    input  logic       csplit_done_i,
    input  logic       tok_vld_i,
    input  logic [1:0] tok_kind_i,
    input  logic       buf_free_i,
    input  logic       buf_full_i,
    input  logic       txn_done_i,
    output logic [1:0] mode_o,
    output logic       setup_valid_o,
    output logic       split_sts_o,
    output logic       hs_vld_o,
    output logic [1:0] hs_code_o,
    output logic       busy_o
);

    logic [MODE_W-1:0] mode_w;
    logic              split_w;
    logic              accept_w;
    logic              open_w;

    ep_mode_ctl #(.SPLIT_EN(SPLIT_EN)) u_ctl (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .host_mode_i    (host_mode_i),
        .sw_wr_en_i     (sw_wr_en_i),
        .sw_wr_data_i   (sw_wr_data_i),
        .valid_clr_i    (valid_clr_i),
        .setup_rx_i     (setup_rx_i),
        .oversize_i     (oversize_i),
        .seq_err_i      (seq_err_i),
        .bus_rst_i      (bus_rst_i),
        .ssplit_issue_i (ssplit_issue_i),
        .csplit_done_i  (csplit_done_i),
        .mode_o         (mode_w),
        .lock_o         (setup_valid_o),
        .split_o        (split_w)
    );

    ep_hs_pick u_pick (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .tok_vld_i      (tok_vld_i),
        .tok_kind_i     (tok_kind_i),
        .mode_i         (mode_w),
        .buf_free_i     (buf_free_i),
        .buf_full_i     (buf_full_i),
        .auto_setaddr_i (auto_setaddr_i),
        .accept_o       (accept_w),
        .hs_vld_o       (hs_vld_o),
        .hs_code_o      (hs_code_o)
    );

    ep_busy_trk u_busy (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .accept_i   (accept_w),
        .txn_done_i (txn_done_i),
        .bus_rst_i  (bus_rst_i),
        .open_o     (open_w)
    );

    generate
        if (SPLIT_EN) begin : g_split_busy
            assign busy_o = open_w | split_w;
        end else begin : g_plain_busy
            assign busy_o = open_w;
        end
    endgenerate

    assign mode_o      = mode_w;
    assign split_sts_o = split_w;

endmodule

// File: rtl/ep_resp_chk.sv
module ep_resp_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       host_mode_i,
    input logic       sw_wr_en_i,
    input logic       setup_rx_i,
    input logic       oversize_i,
    input logic       seq_err_i,
    input logic       bus_rst_i,
    input logic       auto_setaddr_i,
    input logic       csplit_done_i,
    input logic       tok_vld_i,
    input logic [1:0] tok_kind_i,
    input logic [1:0] mode_o,
    input logic       setup_valid_o,
    input logic       split_sts_o,
    input logic       hs_vld_o,
    input logic [1:0] hs_code_o,
    input logic       busy_o
);

    // R3
    nak_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tok_vld_i && !auto_setaddr_i && tok_kind_i != 2'd3 && mode_o == 2'b00
        |=> hs_vld_o && hs_code_o == 2'd0);

    // R3
    stall_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tok_vld_i && !auto_setaddr_i && tok_kind_i != 2'd3 && mode_o[1]
        |=> hs_vld_o && hs_code_o == 2'd3);

    // R5
    setup_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !host_mode_i && setup_rx_i && !bus_rst_i
        |=> mode_o == 2'b00 && setup_valid_o);

    // R6
    lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        setup_valid_o && sw_wr_en_i && !bus_rst_i && !setup_rx_i
        && !seq_err_i && !oversize_i && !csplit_done_i
        |=> $stable(mode_o));

    // R8
    seq_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !host_mode_i && seq_err_i && !setup_rx_i && !bus_rst_i
        |=> mode_o == 2'b10);

    // R9
    bus_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_rst_i |=> mode_o == 2'b00 && !split_sts_o && !busy_o);

    // R11
    auto_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tok_vld_i && auto_setaddr_i && tok_kind_i == 2'd1
        |=> hs_code_o == 2'd2);

    // R13
    split_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        split_sts_o |-> busy_o);

endmodule

bind ep_resp_ctrl ep_resp_chk u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .host_mode_i    (host_mode_i),
    .sw_wr_en_i     (sw_wr_en_i),
    .setup_rx_i     (setup_rx_i),
    .oversize_i     (oversize_i),
    .seq_err_i      (seq_err_i),
    .bus_rst_i      (bus_rst_i),
    .auto_setaddr_i (auto_setaddr_i),
    .csplit_done_i  (csplit_done_i),
    .tok_vld_i      (tok_vld_i),
    .tok_kind_i     (tok_kind_i),
    .mode_o         (mode_o),
    .setup_valid_o  (setup_valid_o),
    .split_sts_o    (split_sts_o),
    .hs_vld_o       (hs_vld_o),
    .hs_code_o      (hs_code_o),
    .busy_o         (busy_o)
);

// File: tb/sim_ep_resp_ctrl.sv
module sim_ep_resp_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_mode = 1'b0;
    logic       sw_wr_en = 1'b0;
    logic [1:0] sw_wr_data = 2'b00;
    logic       valid_clr = 1'b0;
    logic       setup_rx = 1'b0;
    logic       oversize = 1'b0;
    logic       seq_err = 1'b0;
    logic       bus_rst = 1'b0;
    logic       auto_setaddr = 1'b0;
    logic       ssplit_issue = 1'b0;
    logic       csplit_done = 1'b0;
    logic       tok_vld = 1'b0;
    logic [1:0] tok_kind = 2'd0;
    logic       buf_free = 1'b0;
    logic       buf_full = 1'b0;
    logic       txn_done = 1'b0;
    logic [1:0] mode;
    logic       setup_valid;
    logic       split_sts;
    logic       hs_vld;
    logic [1:0] hs_code;
    logic       busy;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [1:0] code;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    ep_resp_ctrl u0 (
        .clk_i(clk), .rst_ni(rst_n), .host_mode_i(host_mode),
        .sw_wr_en_i(sw_wr_en), .sw_wr_data_i(sw_wr_data), .valid_clr_i(valid_clr),
        .setup_rx_i(setup_rx), .oversize_i(oversize), .seq_err_i(seq_err),
        .bus_rst_i(bus_rst), .auto_setaddr_i(auto_setaddr),
        .ssplit_issue_i(ssplit_issue), .csplit_done_i(csplit_done),
        .tok_vld_i(tok_vld), .tok_kind_i(tok_kind), .buf_free_i(buf_free),
        .buf_full_i(buf_full), .txn_done_i(txn_done), .mode_o(mode),
        .setup_valid_o(setup_valid), .split_sts_o(split_sts), .hs_vld_o(hs_vld),
        .hs_code_o(hs_code), .busy_o(busy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    // advance to the next falling edge and drop all strobes
    task automatic step();
        @(negedge clk);
        sw_wr_en = 1'b0; valid_clr = 1'b0; setup_rx = 1'b0; oversize = 1'b0;
        seq_err = 1'b0; bus_rst = 1'b0; ssplit_issue = 1'b0; csplit_done = 1'b0;
        tok_vld = 1'b0; txn_done = 1'b0;
    endtask

    task automatic wr(input logic [1:0] v);
        sw_wr_en = 1'b1; sw_wr_data = v; step();
    endtask

    // driver: pushes the expected handshake, monitor compares
    task automatic send_tok(input logic [1:0] kind, input logic [1:0] exp, input string tag);
        exp_t e;
        e.code = exp; e.tag = tag;
        exp_q.push_back(e);
        tok_vld = 1'b1; tok_kind = kind; step();
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && hs_vld) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected handshake", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk_eq(e.tag, int'(hs_code), int'(e.code));
            end
        end
    end

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_eq("R1 mode", int'(mode), 0);
        chk_eq("R1 lock", int'(setup_valid), 0);
        chk_eq("R1 split", int'(split_sts), 0);
        chk_eq("R1 busy", int'(busy), 0);
        chk_eq("R1 hs_vld", int'(hs_vld), 0);

        send_tok(2'd0, 2'd0, "R3 OUT in NAK mode");
        wr(2'b01);
        chk_eq("R2 write buf", int'(mode), 1);

        // R4 buffer-dependent responses
        buf_free = 1'b1;
        send_tok(2'd0, 2'd1, "R4 OUT free -> ACK");
        chk_eq("R13 busy after ACK", int'(busy), 1);
        txn_done = 1'b1; step();
        chk_eq("R13 busy cleared", int'(busy), 0);
        buf_full = 1'b0;
        send_tok(2'd1, 2'd0, "R4 IN empty -> NAK");
        buf_full = 1'b1;
        send_tok(2'd1, 2'd2, "R4 IN full -> DATA");
        buf_free = 1'b0;
        send_tok(2'd2, 2'd0, "R4 SETUP no buf -> NAK");
        send_tok(2'd3, 2'd0, "R4 reserved -> NAK");
        txn_done = 1'b1; step();

        wr(2'b10);
        send_tok(2'd1, 2'd3, "R3 mode 10 -> STALL");
        wr(2'b11);
        send_tok(2'd0, 2'd3, "R3 mode 11 -> STALL");

        // R7 oversize
        wr(2'b00);
        oversize = 1'b1; step();
        chk_eq("R7 oversize in NAK no effect", int'(mode), 0);
        wr(2'b01);
        oversize = 1'b1; step();
        chk_eq("R7 oversize in BUF -> STALL", int'(mode), 2);

        // R8
        wr(2'b01);
        seq_err = 1'b1; step();
        chk_eq("R8 seq err -> STALL", int'(mode), 2);

        // R5 / R6
        wr(2'b01);
        setup_rx = 1'b1; step();
        chk_eq("R5 setup mode", int'(mode), 0);
        chk_eq("R5 setup lock", int'(setup_valid), 1);
        wr(2'b01);
        chk_eq("R6 locked write dropped", int'(mode), 0);
        valid_clr = 1'b1; sw_wr_en = 1'b1; sw_wr_data = 2'b01; step();
        chk_eq("R6 write with clear dropped", int'(mode), 0);
        chk_eq("R6 lock cleared", int'(setup_valid), 0);
        wr(2'b01);
        chk_eq("R6 write after clear", int'(mode), 1);
        setup_rx = 1'b1; valid_clr = 1'b1; step();
        chk_eq("R6 setup beats clear", int'(setup_valid), 1);

        // R10 priority
        valid_clr = 1'b1; step();
        wr(2'b01);
        setup_rx = 1'b1; seq_err = 1'b1; step();
        chk_eq("R10 setup over stall", int'(mode), 0);
        valid_clr = 1'b1; step();
        sw_wr_en = 1'b1; sw_wr_data = 2'b01; seq_err = 1'b1; step();
        chk_eq("R10 stall over write", int'(mode), 2);
        bus_rst = 1'b1; seq_err = 1'b1; step();
        chk_eq("R10 bus reset over stall", int'(mode), 0);

        // R11 automatic address request ignores the field
        wr(2'b10);
        auto_setaddr = 1'b1;
        send_tok(2'd0, 2'd1, "R11 OUT -> ACK");
        send_tok(2'd1, 2'd2, "R11 IN -> DATA");
        auto_setaddr = 1'b0;
        txn_done = 1'b1; step();

        // R12 split handling
        host_mode = 1'b1;
        wr(2'b01);
        ssplit_issue = 1'b1; step();
        chk_eq("R12 split set", int'(split_sts), 1);
        chk_eq("R13 busy during split", int'(busy), 1);
        wr(2'b00);
        chk_eq("R12 NAK held back", int'(mode), 1);
        buf_full = 1'b1;
        send_tok(2'd1, 2'd2, "R12 split still served");
        csplit_done = 1'b1; step();
        chk_eq("R12 held value applied", int'(mode), 0);
        chk_eq("R12 split cleared", int'(split_sts), 0);
        txn_done = 1'b1; step();
        chk_eq("R13 busy after split", int'(busy), 0);

        // R9 bus reset during a split
        wr(2'b01);
        ssplit_issue = 1'b1; step();
        wr(2'b10);
        bus_rst = 1'b1; step();
        chk_eq("R9 mode", int'(mode), 0);
        chk_eq("R9 split", int'(split_sts), 0);
        chk_eq("R9 busy", int'(busy), 0);
        csplit_done = 1'b1; step();
        chk_eq("R9 held value discarded", int'(mode), 0);

        step();
        chk_eq("R3 scoreboard drained", exp_q.size(), 0);
        finish_up();
    end

endmodule